// File: doc/BRIEF.md
# Run/Step/Halt Clock Controller

This block decides when the processor's clock phases are allowed to run. A free-running oscillator level comes in on `osc_lvl`. The block produces a gated processor clock `cpu_clk` that either follows that oscillator or sits high. A mode switch selects manual or automatic operation. In manual mode, a step pushbutton releases a single clock cycle for each press. In automatic mode the oscillator runs through to the processor. A halt request from the instruction stream holds the clock until an interrupt request arrives. While halted, a step press still lets one cycle through.

The switch and the button are brought into the `clk` domain by a two-stage synchronizer and are then debounced. The run enable is a register that is loaded only at the boundary where the oscillator has just fallen. A cycle therefore always begins at the start of a low phase and is never cut short. The gated clock is the oscillator delayed by two `clk` cycles, with the enable applied.

Top module: `clk_run_ctrl`

## Requirements
- R1: In manual mode (`mode_sw`=0), each debounced press-and-release of `step_btn` (1 = pressed) produces exactly one low-then-high cycle on `cpu_clk`. With no press, `cpu_clk` stays high.
- R2: In automatic mode (`mode_sw`=1, not halted), `cpu_clk` equals `osc_lvl` delayed by two `clk` cycles, so it runs at the oscillator's rate.
- R3: `mode_sw` and `step_btn` pass through a two-flop synchronizer. A new level is accepted only after it has been stable for `DB_TICKS` consecutive `clk` cycles. Shorter pulses have no effect.
- R4: A one-cycle pulse on `halt_req` stops automatic clocking at the next oscillator falling boundary. Clocking stays stopped until `irq_req` is seen.
- R5: While halted, a step press-and-release still produces exactly one full cycle, and the block stays halted afterwards.
- R6: `clk_en` changes only on the cycle after an oscillator falling boundary. `cpu_clk` falls only together with the delayed oscillator and rises only together with it. Every low phase therefore lasts the full oscillator low time.
- R7: Reset (asynchronous assert, synchronous release) clears the halt state and any pending step. It also sets `cpu_clk`=1, `clk_en`=0 and `auto_on`=0.
- R8: `auto_on` is 1 exactly when the debounced mode is automatic and the block is not halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all logic |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| osc_lvl | input | 1 | Free-running oscillator level |
| mode_sw | input | 1 | Mode switch, 1 = automatic, 0 = manual |
| step_btn | input | 1 | Step pushbutton, 1 = pressed |
| halt_req | input | 1 | Halt request from the instruction stream |
| irq_req | input | 1 | Interrupt request, releases halt |
| cpu_clk | output | 1 | Gated processor clock, idles high |
| clk_en | output | 1 | Registered run enable |
| auto_on | output | 1 | Automatic ticking currently enabled |

## Verification
The bench builds the block with `DB_TICKS`=4 and drives an asymmetric oscillator that is high for 3 cycles and low for 5. A full debounce window and several oscillator periods therefore fit into a few dozen cycles. With that setting, the bench can apply 2-cycle glitches that fall short of the debounce window. It can also send steps during a halt and an interrupt that releases it. A monitor measures every low phase, so any truncated phase shows up against the expected length of 5.

// File: rtl/clk_run_pkg.sv
package clk_run_pkg;
  typedef enum logic {
    MODE_MANUAL = 1'b0,
    MODE_AUTO   = 1'b1
  } run_mode_e;
endpackage

// File: rtl/clk_run_debounce.sv
module clk_run_debounce #(
  parameter int DB_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic clean_out
);
  localparam int CW = $clog2(DB_TICKS + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;

  always_comb begin
    cnt_d = '0;
    out_d = out_q;
    if (sync_q[1] != out_q) begin
      if (cnt_q == CW'(DB_TICKS - 1)) begin
        out_d = sync_q[1];
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
      cnt_q  <= '0;
      out_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_in};
      cnt_q  <= cnt_d;
      out_q  <= out_d;
    end
  end

  assign clean_out = out_q;
endmodule

// File: rtl/clk_run_gate.sv
module clk_run_gate
  import clk_run_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      osc_lvl,
  input  run_mode_e mode,
  input  logic      step_db,
  input  logic      halt_req,
  input  logic      irq_req,
  output logic      cpu_clk,
  output logic      clk_en,
  output logic      auto_on,
  output logic      bnd,
  output logic      halted,
  output logic      step_pend,
  output logic      osc_dly
);
  logic osc_q, osc_qq;
  logic btn_q;
  logic en_q, en_d;
  logic halt_q, halt_d;
  logic pend_q, pend_d;
  logic step_rel, auto_run;

  assign bnd      = osc_qq & ~osc_q;
  assign step_rel = btn_q & ~step_db;
  assign auto_run = (mode == MODE_AUTO) & ~(halt_q & ~irq_req);

  always_comb begin
    halt_d = halt_q;
    if (irq_req)       halt_d = 1'b0;
    else if (halt_req) halt_d = 1'b1;
    pend_d = step_rel | (pend_q & ~bnd);
    en_d   = en_q;
    if (bnd) en_d = auto_run | pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q  <= 1'b1;
      osc_qq <= 1'b1;
      btn_q  <= 1'b0;
      en_q   <= 1'b0;
      halt_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      osc_q  <= osc_lvl;
      osc_qq <= osc_q;
      btn_q  <= step_db;
      en_q   <= en_d;
      halt_q <= halt_d;
      pend_q <= pend_d;
    end
  end

  assign cpu_clk   = ~en_q | osc_qq;
  assign clk_en    = en_q;
  assign auto_on   = (mode == MODE_AUTO) & ~halt_q;
  assign halted    = halt_q;
  assign step_pend = pend_q;
  assign osc_dly   = osc_qq;
endmodule

// File: rtl/clk_run_ctrl.sv
module clk_run_ctrl #(
  parameter int DB_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_lvl,
  input  logic mode_sw,
  input  logic step_btn,
  input  logic halt_req,
  input  logic irq_req,
  output logic cpu_clk,
  output logic clk_en,
  output logic auto_on
);
  import clk_run_pkg::*;

  localparam int NDB = 2;

  logic [1:0]     rst_sync_q;
  logic           rst_int_n;
  logic [NDB-1:0] raw_v, db_v;
  logic           bnd, halted, step_pend, osc_dly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign raw_v = {step_btn, mode_sw};

  for (genvar gi = 0; gi < NDB; gi++) begin : g_db
    clk_run_debounce #(.DB_TICKS(DB_TICKS)) u_db (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .raw_in   (raw_v[gi]),
      .clean_out(db_v[gi])
    );
  end

  clk_run_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .osc_lvl  (osc_lvl),
    .mode     (run_mode_e'(db_v[0])),
    .step_db  (db_v[1]),
    .halt_req (halt_req),
    .irq_req  (irq_req),
    .cpu_clk  (cpu_clk),
    .clk_en   (clk_en),
    .auto_on  (auto_on),
    .bnd      (bnd),
    .halted   (halted),
    .step_pend(step_pend),
    .osc_dly  (osc_dly)
  );
endmodule

// File: rtl/clk_run_ctrl_chk.sv
module clk_run_ctrl_chk (
  input logic clk,
  input logic rst_int_n,
  input logic cpu_clk,
  input logic clk_en,
  input logic auto_on,
  input logic bnd,
  input logic halted,
  input logic step_pend,
  input logic osc_dly,
  input logic irq_req
);
  // R6: the enable moves only right after a falling boundary
  a_r6_en_at_boundary: assert property (@(posedge clk) disable iff (!rst_int_n)
    (clk_en != $past(clk_en)) |-> $past(bnd));
  // R6: processor clock falls only with the delayed oscillator
  a_r6_fall_with_osc: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(cpu_clk) |-> $fell(osc_dly));
  // R6: processor clock rises only with the delayed oscillator (no cut low phase)
  a_r6_rise_with_osc: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(cpu_clk) |-> $rose(osc_dly));
  // R4: halted without interrupt or step stops the clock at the boundary
  a_r4_halt_stops: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bnd && halted && !irq_req && !step_pend) |=> !clk_en);
  // R5: a pending step always releases one cycle at the boundary
  a_r5_step_runs: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bnd && step_pend) |=> clk_en);
  // R8: automatic status never reported while halted
  a_r8_status_halt: assert property (@(posedge clk) disable iff (!rst_int_n)
    halted |-> !auto_on);
endmodule

bind clk_run_ctrl clk_run_ctrl_chk u_chk (
  .clk      (clk),
  .rst_int_n(rst_int_n),
  .cpu_clk  (cpu_clk),
  .clk_en   (clk_en),
  .auto_on  (auto_on),
  .bnd      (bnd),
  .halted   (halted),
  .step_pend(step_pend),
  .osc_dly  (osc_dly),
  .irq_req  (irq_req)
);

// File: tb/clk_run_ctrl_tb.sv
module clk_run_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_lvl = 1'b1;
  logic mode_sw = 1'b0, step_btn = 1'b0, halt_req = 1'b0, irq_req = 1'b0;
  logic cpu_clk, clk_en, auto_on;

  int n_run = 0, n_fail = 0;
  int falls = 0, bad_low = 0, low_len = 0;
  logic prev_cpu = 1'b1;

  always #10 clk = ~clk;

  clk_run_ctrl #(.DB_TICKS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_lvl(osc_lvl), .mode_sw(mode_sw),
    .step_btn(step_btn), .halt_req(halt_req), .irq_req(irq_req),
    .cpu_clk(cpu_clk), .clk_en(clk_en), .auto_on(auto_on)
  );

  // oscillator: 3 high, 5 low
  initial begin
    forever begin
      osc_lvl = 1'b1; repeat (3) @(negedge clk);
      osc_lvl = 1'b0; repeat (5) @(negedge clk);
    end
  end

  // monitor of processor clock phases
  always @(negedge clk) begin
    if (prev_cpu && !cpu_clk) begin falls++; low_len = 1; end
    else if (!cpu_clk) low_len++;
    else if (!prev_cpu && low_len != 5) bad_low++;
    prev_cpu = cpu_clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input int hold);
    step_btn = 1'b1; wait_n(hold); step_btn = 1'b0;
  endtask

  task automatic t_reset();
    wait_n(3);
    check(cpu_clk == 1'b1, "R7 cpu_clk", cpu_clk, 1);
    check(clk_en == 1'b0, "R7 clk_en", clk_en, 0);
    check(auto_on == 1'b0, "R7 auto_on", auto_on, 0);
    rst_n = 1'b1; wait_n(20);
  endtask

  task automatic t_manual_idle();
    falls = 0; wait_n(40);
    check(falls == 0, "R1 idle manual", falls, 0);
  endtask

  task automatic t_manual_step();
    falls = 0; press(10); wait_n(40);
    check(falls == 1, "R1 one step", falls, 1);
    falls = 0; press(10); wait_n(30); press(10); wait_n(40);
    check(falls == 2, "R1 two steps", falls, 2);
  endtask

  task automatic t_glitch();
    falls = 0; press(2); wait_n(40);
    check(falls == 0, "R3 step glitch", falls, 0);
    mode_sw = 1'b1; wait_n(2); mode_sw = 1'b0; wait_n(20);
    check(auto_on == 1'b0, "R3 mode glitch", auto_on, 0);
  endtask

  task automatic t_auto();
    mode_sw = 1'b1; wait_n(20);
    check(auto_on == 1'b1, "R8 auto_on", auto_on, 1);
    falls = 0; wait_n(80);
    check(falls >= 9 && falls <= 11, "R2 auto rate", falls, 10);
  endtask

  task automatic t_halt();
    halt_req = 1'b1; wait_n(1); halt_req = 1'b0;
    wait_n(1);
    check(auto_on == 1'b0, "R8 halted status", auto_on, 0);
    wait_n(20); falls = 0; wait_n(80);
    check(falls == 0, "R4 halted", falls, 0);
    check(cpu_clk == 1'b1, "R4 idles high", cpu_clk, 1);
  endtask

  task automatic t_step_halted();
    falls = 0; press(10); wait_n(40);
    check(falls == 1, "R5 step while halted", falls, 1);
    falls = 0; wait_n(40);
    check(falls == 0, "R5 still halted", falls, 0);
  endtask

  task automatic t_irq();
    irq_req = 1'b1; wait_n(1); irq_req = 1'b0;
    wait_n(20); falls = 0; wait_n(80);
    check(falls >= 9, "R4 irq resumes", falls, 10);
    check(auto_on == 1'b1, "R8 resumed status", auto_on, 1);
  endtask

  task automatic t_to_manual();
    mode_sw = 1'b0; wait_n(20); falls = 0; wait_n(40);
    check(falls == 0, "R1 back to manual", falls, 0);
  endtask

  task automatic t_reset_clears();
    mode_sw = 1'b1; wait_n(30);
    halt_req = 1'b1; wait_n(1); halt_req = 1'b0; wait_n(30);
    rst_n = 1'b0; wait_n(3);
    check(clk_en == 1'b0 && cpu_clk == 1'b1, "R7 reset stops", clk_en, 0);
    rst_n = 1'b1; wait_n(30); falls = 0; wait_n(80);
    check(falls >= 9, "R7 halt cleared", falls, 10);
  endtask

  initial begin
    t_reset();
    t_manual_idle();
    t_manual_step();
    t_glitch();
    t_auto();
    t_halt();
    t_step_halted();
    t_irq();
    t_to_manual();
    t_reset_clears();
    check(bad_low == 0, "R6 full low phases", bad_low, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule